// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block paces DRAM refresh. A free-running prescaler divides the system clock by a software-selected power of two. Each prescaled tick advances an up-counter, which is compared against a programmable constant. When the counter reaches the constant, the block sets a match flag. If refresh is enabled, it also sends a one-cycle refresh request to the DRAM cycle generator. On the following tick the counter restarts from zero, so requests repeat every (constant + 1) ticks. Generating the RAS/CAS cycles and multiplexing the addresses are done elsewhere.

Software programs the block through a small register port with four registers: control, timer status/select, counter and constant. The first match after reset, or after the device leaves either standby state, only sets the flag and does not request a refresh. Software can count flag events to time the DRAM power-up wait.

The power inputs act as follows:
- Sleep leaves the timer running.
- Hardware standby freezes it.
- Software standby zeroes the counter and prescaler and keeps every setting.

The bus port is a plain register interface with no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge it is presented on. Read data is combinational from the selected register.

Top module: `dram_refresh_timer`

## Requirements
- R1: After reset every register reads 0, the match flag is low and no refresh request is issued.
- R2: Register select 0 is control, 1 is status/select, 2 is the counter, 3 is the constant. The counter and the constant are readable and writable. Control bit 0 is the refresh enable; other control bits read 0.
- R3: Status bits 5:3 choose the tick divisor: 001 gives 2, 010 gives 8, 011 gives 32, 100 gives 128, 101 gives 512, 110 gives 2048 and 111 gives 4096. Code 000 stops the counter.
- R4: A tick that brings the counter to the constant sets the match flag (status bit 7) in the same edge. The next tick returns the counter to 0, so successive matches are (constant + 1) ticks apart.
- R5: The match flag is cleared only by a status write with bit 7 = 0 that follows a status read that returned bit 7 = 1. Writing 1 has no effect, and writing 0 without such a read has no effect. A match in the same cycle wins over a clear.
- R6: The first match after reset, after hardware standby or after software standby sets the flag but issues no request. Later matches issue requests.
- R7: The refresh request is a pulse of exactly one cycle, asserted together with the flag, and only when the refresh enable is 1.
- R8: Sleep mode has no effect. The counter keeps running and requests keep coming.
- R9: While hardware standby is high, the prescaler and the counter hold their values and no request is issued.
- R10: While software standby is high, the counter and prescaler are held at 0. Control, the divisor select and the constant keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_mode | input | 1 | Device sleep state (timer keeps running) |
| sw_standby | input | 1 | Software standby: counter cleared, settings kept |
| hw_standby | input | 1 | Hardware standby: timer frozen |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| refresh_req | output | 1 | One-cycle refresh request |
| match_flag | output | 1 | Compare-match flag (same as status bit 7) |

## Verification
Results fall due as follows:
- The counter, the flag and the request all update at the clock edge of the prescaler tick that reaches the constant. The bench therefore sees the flag and the request together, at the first falling edge after that tick.
- A write lands at the rising edge that ends its cycle.
- Read data is valid within the cycle in which it is selected.

The bench drives and samples only on falling edges. It measures request spacing by counting falling edges between pulses, where the expected count is divisor × (constant + 1). The first-match rule is checked by counting requests until the flag's first rise, where zero is expected.

// File: rtl/dram_rt_pkg.sv
package dram_rt_pkg;

  // Register select codes on the bus port
  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT  = 2'd1,
    RA_COUNT = 2'd2,
    RA_CONST = 2'd3
  } reg_addr_e;

  // Widest divisor is 4096, so the prescaler needs 12 bits
  localparam int unsigned PRE_W    = 12;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned SEL_LO   = 3;
  localparam int unsigned SEL_HI   = SEL_LO + SEL_W - 1;
  localparam int unsigned EN_BIT   = 0;

  // Low-bit mask whose all-ones state marks one prescaled tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] code);
    logic [PRE_W-1:0] m;
    case (code)
      3'd1:    m = PRE_W'(12'h001);
      3'd2:    m = PRE_W'(12'h007);
      3'd3:    m = PRE_W'(12'h01F);
      3'd4:    m = PRE_W'(12'h07F);
      3'd5:    m = PRE_W'(12'h1FF);
      3'd6:    m = PRE_W'(12'h7FF);
      3'd7:    m = PRE_W'(12'hFFF);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import dram_rt_pkg::*;
#(
  parameter int unsigned WIDTH = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hold,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);

  logic [WIDTH-1:0] pre_q;
  logic [WIDTH-1:0] mask;
  logic             running;

  assign mask    = WIDTH'(div_mask(code));
  assign running = (code != '0) && !clear && !hold;
  assign tick    = running && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (!hold) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             at_limit;

  assign at_limit = (cnt_q == limit);
  assign cnt_next = at_limit ? '0 : cnt_q + 1'b1;
  // A match event is the tick that brings the counter onto the limit
  assign hit      = tick && !clear && !load && (cnt_next == limit);
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import dram_rt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             hit,
  input  logic             standby_any,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] limit,
  output logic [SEL_W-1:0] div_code,
  output logic             refresh_en,
  output logic             flag,
  output logic             req
);

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] const_q;
  logic             flag_q;
  logic             arm_q;
  logic             skip_q;
  logic             req_q;
  logic             wr_ctrl;
  logic             wr_stat;
  logic             wr_const;
  logic             rd_stat;
  logic             clr_req;

  assign wr_ctrl  = wr_en && (reg_sel == RA_CTRL);
  assign wr_stat  = wr_en && (reg_sel == RA_STAT);
  assign wr_const = wr_en && (reg_sel == RA_CONST);
  assign rd_stat  = rd_en && (reg_sel == RA_STAT);
  assign clr_req  = wr_stat && !wr_data[FLAG_BIT] && arm_q;

  // Configuration registers: untouched by either standby state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      const_q <= '0;
    end else begin
      if (wr_ctrl)  en_q    <= wr_data[EN_BIT];
      if (wr_stat)  sel_q   <= wr_data[SEL_HI:SEL_LO];
      if (wr_const) const_q <= wr_data;
    end
  end

  // Flag with read-then-write-zero clear; a new match beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (hit) begin
        flag_q <= 1'b1;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
      if (wr_stat) begin
        arm_q <= 1'b0;
      end else if (rd_stat && flag_q) begin
        arm_q <= 1'b1;
      end
    end
  end

  // Skip latch: armed by reset and by any standby, spent by a match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      if (standby_any) begin
        skip_q <= 1'b1;
      end else if (hit) begin
        skip_q <= 1'b0;
      end
      req_q <= hit && en_q && !skip_q && !standby_any;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      RA_CTRL:  rd_data[EN_BIT] = en_q;
      RA_STAT: begin
        rd_data[FLAG_BIT]      = flag_q;
        rd_data[SEL_HI:SEL_LO] = sel_q;
      end
      RA_COUNT: rd_data = count;
      default:  rd_data = const_q;
    endcase
  end

  assign limit      = const_q;
  assign div_code   = sel_q;
  assign refresh_en = en_q;
  assign flag       = flag_q;
  assign req        = req_q;

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
  import dram_rt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_mode,
  input  logic             sw_standby,
  input  logic             hw_standby,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] rd_data,
  output logic             refresh_req,
  output logic             match_flag
);

  logic             tick;
  logic             hit;
  logic             standby_any;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] const_val;
  logic [SEL_W-1:0] div_code;
  logic             refresh_en;

  // Sleep is deliberately absent here: the timer runs through it.
  assign standby_any = sw_standby || hw_standby;
  assign cnt_load    = wr_en && (reg_sel == RA_COUNT);

  rt_prescaler #(.WIDTH(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sw_standby),
    .hold  (hw_standby),
    .code  (div_code),
    .tick  (tick)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sw_standby),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (wr_data),
    .limit    (const_val),
    .count    (cnt_val),
    .hit      (hit)
  );

  rt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .hit         (hit),
    .standby_any (standby_any),
    .count       (cnt_val),
    .rd_data     (rd_data),
    .limit       (const_val),
    .div_code    (div_code),
    .refresh_en  (refresh_en),
    .flag        (match_flag),
    .req         (refresh_req)
  );

endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import dram_rt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_mode,
  input logic             sw_standby,
  input logic             hw_standby,
  input logic             wr_en,
  input logic [1:0]       reg_sel,
  input logic             refresh_req,
  input logic             match_flag,
  input logic             refresh_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] const_val
);

  p_req_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> refresh_en);

  p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |=> !refresh_req);

  p_req_with_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> match_flag);

  p_flag_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) && !$past(wr_en && (reg_sel == RA_CONST)) |-> (cnt_val == const_val));

  p_hw_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> !refresh_req);

  p_hw_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby && !sw_standby && !(wr_en && (reg_sel == RA_COUNT)) |=> $stable(cnt_val));

  p_sw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_standby |=> (cnt_val == '0));

  p_sw_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_standby && !wr_en |=> $stable(const_val) && $stable(refresh_en));

  p_sleep_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode && !sw_standby && !hw_standby && !(wr_en && (reg_sel == RA_COUNT))
      && (cnt_val != '0) && (cnt_val != const_val) && (cnt_val != '1)
      |=> (cnt_val != '0));

endmodule

bind dram_refresh_timer rt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_mode  (sleep_mode),
  .sw_standby  (sw_standby),
  .hw_standby  (hw_standby),
  .wr_en       (wr_en),
  .reg_sel     (reg_sel),
  .refresh_req (refresh_req),
  .match_flag  (match_flag),
  .refresh_en  (refresh_en),
  .cnt_val     (cnt_val),
  .const_val   (const_val)
);

// File: tb/test_dram_refresh_timer.sv
module test_dram_refresh_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_mode = 1'b0;
  logic       sw_standby = 1'b0;
  logic       hw_standby = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       refresh_req;
  logic       match_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dram_refresh_timer i_dram_refresh_timer (
    .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .sw_standby(sw_standby),
    .hw_standby(hw_standby), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .refresh_req(refresh_req), .match_flag(match_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_mode = 0; sw_standby = 0; hw_standby = 0;
    wr_en = 0; rd_en = 0; reg_sel = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    reg_sel = sel; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic setup(input logic [2:0] code, input logic [7:0] k, input bit en);
    wr(2'd3, k);
    wr(2'd0, {7'd0, en});
    wr(2'd1, {2'b00, code, 3'b000});
  endtask

  task automatic wait_flag(input int maxc, output int reqs, output bit ok);
    reqs = 0; ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (refresh_req) reqs++;
      if (match_flag) begin ok = 1; break; end
    end
  endtask

  task automatic wait_req(input int maxc, output int cyc, output bit ok);
    cyc = 0; ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      cyc++;
      if (refresh_req) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 8'd0, "R1 register zero after reset", d, 0);
    end
    chk(!match_flag && !refresh_req, "R1 flag/request low", {match_flag, refresh_req}, 0);
    wr(2'd3, 8'h5A); rd(2'd3, d);
    chk(d == 8'h5A, "R2 constant read back", d, 8'h5A);
    wr(2'd0, 8'hFF); rd(2'd0, d);
    chk(d == 8'h01, "R2 control only enable bit", d, 1);
  endtask

  task automatic t_skip_first();
    int n; bit ok; logic [7:0] d;
    do_reset();
    setup(3'd1, 8'd3, 1'b1);
    wait_flag(100, n, ok);
    chk(ok, "R4 flag sets on match", ok, 1);
    chk(n == 0, "R6 no request on first match", n, 0);
    rd(2'd2, d);
    chk(d == 8'd3, "R4 counter equals constant at flag", d, 3);
    wait_req(100, n, ok);
    chk(ok && n == 7, "R6 second match requests", n, 7);
  endtask

  task automatic t_period();
    int n; bit ok;
    do_reset();
    setup(3'd1, 8'd3, 1'b1);
    wait_req(200, n, ok);
    wait_req(200, n, ok);
    chk(ok && n == 8, "R4 period div2 const3", n, 8);
    @(negedge clk);
    chk(!refresh_req, "R7 request one cycle", refresh_req, 0);
    wr(2'd1, {2'b00, 3'd2, 3'b000});
    wr(2'd3, 8'd1);
    wait_req(400, n, ok);
    wait_req(400, n, ok);
    chk(ok && n == 16, "R3 period div8 const1", n, 16);
    wr(2'd1, {2'b00, 3'd3, 3'b000});
    wait_req(400, n, ok);
    wait_req(400, n, ok);
    chk(ok && n == 64, "R3 period div32 const1", n, 64);
  endtask

  task automatic t_stop();
    logic [7:0] a, b;
    do_reset();
    setup(3'd0, 8'd3, 1'b1);
    wr(2'd2, 8'd5);
    rd(2'd2, a);
    repeat (40) @(negedge clk);
    rd(2'd2, b);
    chk(a == 8'd5 && b == 8'd5, "R3 code 000 stops counter", b, 5);
    chk(!match_flag, "R3 no match while stopped", match_flag, 0);
  endtask

  task automatic t_flag_clear();
    int n; bit ok; logic [7:0] d;
    do_reset();
    setup(3'd1, 8'd0, 1'b0);
    wait_flag(50, n, ok);
    wr(2'd1, 8'b1000_0000);
    @(negedge clk);
    chk(match_flag, "R5 write 1 leaves flag", match_flag, 1);
    wr(2'd1, 8'b0000_0000);
    @(negedge clk);
    chk(match_flag, "R5 write 0 without read leaves flag", match_flag, 1);
    rd(2'd1, d);
    chk(d[7] == 1'b1, "R5 status bit7 reads 1", d[7], 1);
    wr(2'd1, 8'b0000_0000);
    chk(!match_flag, "R5 read then write 0 clears", match_flag, 0);
  endtask

  task automatic t_enable_off();
    int n; bit ok;
    do_reset();
    setup(3'd1, 8'd1, 1'b0);
    wait_flag(50, n, ok);
    wait_req(80, n, ok);
    chk(!ok, "R7 no request when disabled", ok, 0);
    chk(match_flag, "R7 flag still set when disabled", match_flag, 1);
  endtask

  task automatic t_sleep();
    int n; bit ok;
    do_reset();
    sleep_mode = 1'b1;
    setup(3'd1, 8'd3, 1'b1);
    wait_req(200, n, ok);
    chk(ok, "R8 request during sleep", ok, 1);
    wait_req(200, n, ok);
    chk(ok && n == 8, "R8 period unchanged in sleep", n, 8);
    sleep_mode = 1'b0;
  endtask

  task automatic t_hw_standby();
    int n, reqs; bit ok; logic [7:0] a, b, d;
    do_reset();
    setup(3'd1, 8'd7, 1'b1);
    wait_req(200, n, ok);
    repeat (5) @(negedge clk);
    hw_standby = 1'b1;
    @(negedge clk);
    rd(2'd2, a);
    reqs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (refresh_req) reqs++;
    end
    rd(2'd2, b);
    chk(a == b, "R9 counter frozen", b, a);
    chk(reqs == 0, "R9 no requests in hw standby", reqs, 0);
    rd(2'd1, d);
    wr(2'd1, {2'b00, 3'd1, 3'b000});
    hw_standby = 1'b0;
    wait_flag(100, n, ok);
    chk(ok && n == 0, "R6 first match after hw standby skipped", n, 0);
    wait_req(100, n, ok);
    chk(ok && n == 16, "R6 later match after hw standby requests", n, 16);
  endtask

  task automatic t_sw_standby();
    int n; bit ok; logic [7:0] d;
    do_reset();
    setup(3'd1, 8'd9, 1'b1);
    wait_req(200, n, ok);
    repeat (5) @(negedge clk);
    rd(2'd1, d);
    wr(2'd1, {2'b00, 3'd1, 3'b000});
    sw_standby = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd2, d);
    chk(d == 8'd0, "R10 counter cleared", d, 0);
    rd(2'd3, d);
    chk(d == 8'd9, "R10 constant kept", d, 9);
    rd(2'd1, d);
    chk(d[5:3] == 3'd1, "R10 divisor select kept", d[5:3], 1);
    rd(2'd0, d);
    chk(d == 8'd1, "R10 enable kept", d, 1);
    sw_standby = 1'b0;
    wait_flag(200, n, ok);
    chk(ok && n == 0, "R6 first match after sw standby skipped", n, 0);
    wait_req(200, n, ok);
    chk(ok && n == 20, "R6 later match after sw standby requests", n, 20);
  endtask

  initial begin
    t_reset();
    t_skip_first();
    t_period();
    t_stop();
    t_flag_clear();
    t_enable_off();
    t_sleep();
    t_hw_standby();
    t_sw_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule